// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-Up Control

This block is a general-purpose pin port of sixteen bidirectional pins behind a single-cycle register bus. One 32-bit control word sets up every pin with two bits: one chooses whether the pin drives or listens, the other chooses whether the pad's pull-up resistor is enabled. A second register holds a data latch with one bit per pin. Toward the pad, each pin gets an output enable, an output value and a pull-up enable. The pad level comes back through a synchronizer clocked by the bus clock.

A read of the data register merges two sources bit by bit. Pins set to drive return their latched value. Pins set to listen return the synchronized pad level. The pull-up is always disabled on a driving pin, whatever its control bit holds. The data latch has no reset, so a pin pattern written before a reset is still there afterwards. The control word does return to all-input after a reset. Software can therefore restore the directions and pick up the earlier output values without writing the latch again.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and right after it, the control register reads 0x00000000, every output enable is low and every pull-up enable is high.
- R2: Control bit 2n selects the direction of pin n: 1 drives the pin (output enable high) and 0 leaves it as an input. The new direction applies from the clock edge that takes the write.
- R3: On an input pin n, control bit 2n+1 at 0 enables the pull-up and at 1 disables it.
- R4: The pull-up enable of a pin is low whenever that pin is an output, whatever bit 2n+1 holds.
- R5: The output value driven to pad n equals bit n of the data latch.
- R6: A data register read returns the latch bit for output pins and, for input pins, the pad level captured two rising clock edges earlier. A read returns its value combinationally in the cycle the address is presented.
- R7: The data latch is not cleared by reset and keeps the value written before it.
- R8: A data register write updates the latch bits of input pins as well. The stored value drives such a pin once it is switched to output.
- R9: Only byte offsets 0x0 (control) and 0x4 (data) are mapped. Any other offset reads 0, and a write to it changes neither register.
- R10: Reading the control register returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also clocks the input synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset (control and synchronizer only) |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Pad levels as seen from outside |
| pad_out | output | 16 | Output value per pin |
| pad_oe | output | 16 | Output enable per pin, 1 = drive |
| pad_pu_en | output | 16 | Pull-up enable per pin, 1 = pull-up active |

## Verification
A register write is due at the pad outputs and on readback one rising edge after it is presented. A read is due in the same cycle as its address. A pad change reaches an input bit of the read data only after the second rising edge. The bench drives every stimulus on a falling edge and samples a nanosecond after a later falling edge. For a pad change, it checks once after the first rising edge that the old level is still shown, then checks after the second edge that the new level has appeared.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned BUS_W      = 32;
   localparam int unsigned OFS_CTRL   = 0;
   localparam int unsigned OFS_DATA   = 4;
   localparam int unsigned BITS_PER_PIN = 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_DATA = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
   end
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] q
);
   // No reset by intent: contents survive every reset.
   always_ff @(posedge clk) begin
      if (wr_en) q <= wr_data;
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[s] <= '0;
         else        stage[s] <= stage[s-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
   input  logic dir_out,
   input  logic pu_off,
   input  logic latch_bit,
   input  logic synced_in,
   output logic oe,
   output logic pu_en,
   output logic out_val,
   output logic rd_bit
);
   assign oe      = dir_out;
   assign pu_en   = ~pu_off & ~dir_out;
   assign out_val = latch_bit;
   assign rd_bit  = dir_out ? latch_bit : synced_in;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_COUNT   = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [PIN_COUNT-1:0] pad_pu_en
);
   localparam int unsigned CTRL_W = BITS_PER_PIN * PIN_COUNT;

   if (PIN_COUNT < 1 || CTRL_W > BUS_W) begin : g_bad_pins
      $error("gpio_port: PIN_COUNT must be 1..%0d", BUS_W / BITS_PER_PIN);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end
   if ((1 << ADDR_W) <= OFS_DATA) begin : g_bad_addr
      $error("gpio_port: ADDR_W too narrow for the register map");
   end

   reg_sel_e              sel;
   logic [CTRL_W-1:0]     ctrl_q;
   logic [PIN_COUNT-1:0]  latch_q;
   logic [PIN_COUNT-1:0]  synced;
   logic [PIN_COUNT-1:0]  rd_bits;

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
      else                                    sel = SEL_NONE;
   end

   gpio_ctrl_reg #(.WIDTH(CTRL_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we && sel == SEL_CTRL),
      .wr_data (bus_wdata[CTRL_W-1:0]),
      .q       (ctrl_q)
   );

   gpio_data_latch #(.WIDTH(PIN_COUNT)) u_latch (
      .clk     (clk),
      .wr_en   (bus_we && sel == SEL_DATA),
      .wr_data (bus_wdata[PIN_COUNT-1:0]),
      .q       (latch_q)
   );

   gpio_in_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (synced)
   );

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      gpio_pin_cell u_cell (
         .dir_out   (ctrl_q[BITS_PER_PIN*p]),
         .pu_off    (ctrl_q[BITS_PER_PIN*p+1]),
         .latch_bit (latch_q[p]),
         .synced_in (synced[p]),
         .oe        (pad_oe[p]),
         .pu_en     (pad_pu_en[p]),
         .out_val   (pad_out[p]),
         .rd_bit    (rd_bits[p])
      );
   end

   always_comb begin
      case (sel)
         SEL_CTRL: bus_rdata = BUS_W'(ctrl_q);
         SEL_DATA: bus_rdata = BUS_W'(rd_bits);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_COUNT = 16,
   parameter int unsigned ADDR_W    = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_we,
   input logic [BUS_W-1:0]     bus_wdata,
   input logic [BUS_W-1:0]     bus_rdata,
   input logic [PIN_COUNT-1:0] pad_out,
   input logic [PIN_COUNT-1:0] pad_oe,
   input logic [PIN_COUNT-1:0] pad_pu_en
);
   logic [PIN_COUNT-1:0] dir_bits;
   logic                 hit_ctrl, hit_data, hit_none;

   always_comb begin
      for (int p = 0; p < PIN_COUNT; p++) dir_bits[p] = bus_wdata[BITS_PER_PIN*p];
   end
   assign hit_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
   assign hit_data = bus_addr == ADDR_W'(OFS_DATA);
   assign hit_none = !hit_ctrl && !hit_data;

   // R1: all inputs with pull-ups on while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_pins: assert (pad_oe == '0 && pad_pu_en == '1)
            else $error("R1 pin state under reset");
      end
   end

   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_ctrl) |=> pad_oe == $past(dir_bits));

   a_r4_pu_off_on_output: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu_en) == '0);

   a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && hit_data) |=> $stable(pad_out));

   a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hit_none |-> bus_rdata == '0);

   a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_none) |=> ($stable(pad_oe) && $stable(pad_pu_en) && $stable(pad_out)));
endmodule

bind gpio_port gpio_port_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pad_pu_en (pad_pu_en)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, pad_pu_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   gpio_port u_gpio_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      #1;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(4'h0, v);
      check("R1 ctrl after reset", v, 32'h0);
      check("R1 oe after reset", {16'h0, pad_oe}, 32'h0);
      check("R1 pull-up after reset", {16'h0, pad_pu_en}, 32'h0000FFFF);
   endtask

   task automatic t_direction();
      logic [31:0] v;
      wr(4'h0, 32'h0000_5555);
      check("R2 low pins output", {16'h0, pad_oe}, 32'h0000_00FF);
      rd(4'h0, v);
      check("R10 ctrl readback", v, 32'h0000_5555);
   endtask

   task automatic t_pullup();
      wr(4'h0, 32'hAAAA_0000);
      check("R3 pull-up per bit", {16'h0, pad_pu_en}, 32'h0000_00FF);
      wr(4'h0, 32'h5555_5555);
      check("R4 outputs force pull-up off", {16'h0, pad_pu_en}, 32'h0);
      check("R2 all outputs", {16'h0, pad_oe}, 32'h0000_FFFF);
   endtask

   task automatic t_output();
      logic [31:0] v;
      wr(4'h4, 32'h0000_1234);
      check("R5 pad_out follows latch", {16'h0, pad_out}, 32'h0000_1234);
      rd(4'h4, v);
      check("R6 output read returns latch", v, 32'h0000_1234);
   endtask

   task automatic t_input();
      logic [31:0] v;
      wr(4'h0, 32'h0);
      @(negedge clk); pad_in = 16'h0000;
      repeat (3) @(negedge clk);
      bus_addr = 4'h4; pad_in = 16'hBEEF;
      @(negedge clk); #1;
      check("R6 one edge, old level", bus_rdata, 32'h0);
      @(negedge clk); #1;
      check("R6 two edges, new level", bus_rdata, 32'h0000_BEEF);
      wr(4'h0, 32'h0000_5555);
      rd(4'h4, v);
      check("R6 mixed direction read", v, 32'h0000_BE34);
   endtask

   task automatic t_latch_input();
      logic [31:0] v;
      wr(4'h0, 32'h0);
      wr(4'h4, 32'h0000_5A5A);
      rd(4'h4, v);
      check("R8 input pins still read pads", v, 32'h0000_BEEF);
      wr(4'h0, 32'h5555_5555);
      check("R8 latched value driven", {16'h0, pad_out}, 32'h0000_5A5A);
      rd(4'h4, v);
      check("R8 latched value read", v, 32'h0000_5A5A);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, v);
      check("R9 unmapped reads zero", v, 32'h0);
      rd(4'h0, v);
      check("R9 ctrl untouched", v, 32'h5555_5555);
      rd(4'h4, v);
      check("R9 latch untouched", v, 32'h0000_5A5A);
      check("R9 pull-ups untouched", {16'h0, pad_pu_en}, 32'h0);
   endtask

   task automatic t_retain();
      logic [31:0] v;
      wr(4'h4, 32'h0000_A5C3);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(4'h0, v);
      check("R1 ctrl cleared by reset", v, 32'h0);
      wr(4'h0, 32'h5555_5555);
      rd(4'h4, v);
      check("R7 latch kept through reset", v, 32'h0000_A5C3);
      check("R7 pad_out kept through reset", {16'h0, pad_out}, 32'h0000_A5C3);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direction();
      t_pullup();
      t_output();
      t_input();
      t_latch_input();
      t_unmapped();
      t_retain();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule